// File: doc/BRIEF.md
# Opcode-Fetch-Aligned Bus Loop Checker

This block watches the bus of an 8-bit processor with a 16-bit address space, one sample per processor clock cycle. It is meant for bring-up of a new board: the processor runs a short, known instruction loop, and the checker confirms cycle by cycle that every fetch and every operand access goes to the expected address with the expected data. It uses the processor's opcode-fetch indicator (SYNC) as its time reference, so no external trigger is needed.

A programmable table holds one expected cycle per entry: an address, a data byte, the expected SYNC level, and per-bit care masks for address and data so that unpredictable lines can be excluded. A length register selects how many entries form the loop. The sample strobe should be asserted near the end of each processor cycle, when the data lines are valid. The checker waits for the first SYNC-high sample and aligns entry 0 to it. From then on it steps through the table and wraps. It latches the details of the first mismatch, flags a SYNC pulse seen in a position not marked as an opcode fetch, and counts loop passes that matched completely.

Typical tables are a three-cycle jump-to-self loop at $C000 (opcode $4C, operand bytes $00 and $C0) and a seven-cycle loop made of a four-cycle absolute load from $8000 followed by that jump.

Top module: `bus_loop_checker`

## Requirements
- R1: After reset, `aligned`, `failFlag`, `syncErr`, `passFlag` and `loopCount` are 0. No sample is compared, and none changes any output, until a sample with `busSync`=1 arrives.
- R2: The first SYNC-high sample aligns the checker to entry 0 and is compared with entry 0. Each later sample is compared with the next entry, and the entry after entry (length-1) is entry 0.
- R3: A compare fails if any address bit whose care bit is 1 differs, if any data bit whose care bit is 1 differs, or if `busSync` differs from the entry's SYNC level. Bits whose care bit is 0 are never compared.
- R4: Only clock cycles with `sampleEn`=1 are observed. Bus values in other cycles have no effect.
- R5: When `busSync`=1 arrives at an entry whose SYNC level is 1, the position is kept. When it arrives at an entry whose SYNC level is 0, the sticky `syncErr` is set, the checker realigns, and that sample is compared with entry 0.
- R6: The first failed compare sets `failFlag` and latches the entry index and the observed and expected address, data and SYNC. Later failures change none of these. A `clearErr` pulse zeroes them and `syncErr`, which allows the next failure to be latched.
- R7: `loopCount` increments by one for each pass from entry 0 to the last entry in which every compare matched. It saturates at 65535 and only reset clears it.
- R8: `passFlag` is 1 exactly when `loopCount` is nonzero and neither `failFlag` nor `syncErr` is set.
- R9: Writing the length with `cfgLenWr` stores 1 for a value of 0 and stores DEPTH for a value above DEPTH. The write also drops alignment, so the checker waits for the next SYNC-high sample.
- R10: `cfgWr` writes one table entry at `cfgIdx`. The entry fields are address, address care mask, data, data care mask and SYNC level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Checker clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | One pulse per processor cycle, placed late in the cycle |
| busAddr | input | 16 | Observed address |
| busData | input | 8 | Observed data |
| busSync | input | 1 | Observed opcode-fetch indicator |
| cfgWr | input | 1 | Table entry write strobe |
| cfgIdx | input | $clog2(DEPTH) | Entry index for write |
| cfgAddr | input | 16 | Expected address |
| cfgAddrCare | input | 16 | Address compare mask, 1 = compare |
| cfgData | input | 8 | Expected data |
| cfgDataCare | input | 8 | Data compare mask, 1 = compare |
| cfgSync | input | 1 | Expected SYNC level |
| cfgLenWr | input | 1 | Loop length write strobe |
| cfgLen | input | $clog2(DEPTH+1) | Loop length value |
| clearErr | input | 1 | Clears the failure latch and syncErr |
| aligned | output | 1 | Checker is locked to the loop |
| passFlag | output | 1 | At least one clean pass and no error |
| failFlag | output | 1 | Sticky compare failure |
| syncErr | output | 1 | Sticky misplaced SYNC |
| failIdx | output | $clog2(DEPTH) | Entry index of the first failure |
| failObsAddr | output | 16 | Observed address at the failure |
| failObsData | output | 8 | Observed data at the failure |
| failObsSync | output | 1 | Observed SYNC at the failure |
| failExpAddr | output | 16 | Expected address at the failure |
| failExpData | output | 8 | Expected data at the failure |
| failExpSync | output | 1 | Expected SYNC at the failure |
| loopCount | output | 16 | Saturating count of clean passes |

## Verification
Assertions check on every cycle that the index stays within the active length once aligned, that an unaligned checker stays unaligned without a SYNC sample, that a misplaced SYNC moves the index to one past entry 0, that the failure latch and `syncErr` stay stable until cleared, that the stored length stays between 1 and DEPTH, and that the pass count never drops and stays at its ceiling. Only the bench scenarios can show that the right passes are counted and the right cycle is latched. These scenarios are: the jump and load-plus-jump loops, entry into the loop at a rotated point, gaps in the sample strobe, masked bits, address, data and SYNC mismatches, a misplaced SYNC, length clamping, and count saturation.

// File: rtl/blc_pkg.sv
package blc_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;

  // One expected bus cycle
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] addrCare;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] dataCare;
    logic              sync;
  } cycEntry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic doCompare;
    logic latchMiss;
    logic bumpCount;
    logic flagSync;
  } ctlStrobe_t;
endpackage

// File: rtl/blc_ctrl.sv
module blc_ctrl
  import blc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEn,
  input  logic             busSync,
  input  logic             lenWr,
  input  logic             curEntrySync,
  input  logic [IDX_W-1:0] lastIdx,
  input  logic             mismatch,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] effIdx,
  output logic             aligned,
  output ctlStrobe_t       strb
);
  logic passClean;
  logic realignNow, misplaced, compareNow, isLast, passOk;

  always_comb begin
    realignNow = sampleEn && busSync && (!aligned || !curEntrySync);
    misplaced  = sampleEn && busSync && aligned && !curEntrySync;
    compareNow = sampleEn && (aligned || busSync) && !lenWr;
    effIdx     = realignNow ? '0 : idx;
    isLast     = (effIdx == lastIdx);
    passOk     = ((effIdx == '0) || passClean) && !mismatch;
    strb.doCompare = compareNow;
    strb.latchMiss = compareNow && mismatch;
    strb.bumpCount = compareNow && isLast && passOk;
    strb.flagSync  = misplaced && !lenWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aligned   <= 1'b0;
      idx       <= '0;
      passClean <= 1'b0;
    end else if (lenWr) begin
      aligned   <= 1'b0;
      idx       <= '0;
      passClean <= 1'b0;
    end else if (compareNow) begin
      aligned   <= 1'b1;
      idx       <= isLast ? '0 : effIdx + 1'b1;
      passClean <= passOk;
    end
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    aligned |-> (idx <= lastIdx));
  // R1
  hold_unaligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!aligned && !(sampleEn && busSync)) |=> !aligned);
  // R5
  realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && busSync && aligned && !curEntrySync && !lenWr)
      |=> (idx == (($past(lastIdx) == '0) ? '0 : IDX_W'(1))));
endmodule

// File: rtl/blc_dpath.sv
module blc_dpath
  import blc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  cycEntry_t         cfgEntry,
  input  logic              cfgLenWr,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              clearErr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busSync,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  effIdx,
  input  ctlStrobe_t        strb,
  output logic              curEntrySync,
  output logic [IDX_W-1:0]  lastIdx,
  output logic              mismatch,
  output logic              failFlag,
  output logic              syncErr,
  output logic [IDX_W-1:0]  failIdx,
  output logic [ADDR_W-1:0] failObsAddr,
  output logic [DATA_W-1:0] failObsData,
  output logic              failObsSync,
  output logic [ADDR_W-1:0] failExpAddr,
  output logic [DATA_W-1:0] failExpData,
  output logic              failExpSync,
  output logic [CNT_W-1:0]  loopCount
);
  cycEntry_t        tbl [DEPTH];
  logic [LEN_W-1:0] loopLen;
  cycEntry_t        expE;
  logic             addrBad, dataBad, syncBad;

  // Table entries, one register per slot
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN)
        tbl[g] <= '0;
      else if (cfgWr && (cfgIdx == IDX_W'(g)))
        tbl[g] <= cfgEntry;
    end
  end

  // Length register with clamping
  always_ff @(posedge clk) begin
    if (!rstN)
      loopLen <= LEN_W'(DEPTH);
    else if (cfgLenWr) begin
      if (cfgLen == '0)
        loopLen <= LEN_W'(1);
      else if (cfgLen > LEN_W'(DEPTH))
        loopLen <= LEN_W'(DEPTH);
      else
        loopLen <= cfgLen;
    end
  end

  always_comb begin
    lastIdx      = IDX_W'(loopLen - 1'b1);
    curEntrySync = tbl[idx].sync;
    expE         = tbl[effIdx];
    addrBad      = |((busAddr ^ expE.addr) & expE.addrCare);
    dataBad      = |((busData ^ expE.data) & expE.dataCare);
    syncBad      = (busSync != expE.sync);
    mismatch     = addrBad || dataBad || syncBad;
  end

  // First-failure latch
  always_ff @(posedge clk) begin
    if (!rstN || clearErr) begin
      failFlag    <= 1'b0;
      failIdx     <= '0;
      failObsAddr <= '0;
      failObsData <= '0;
      failObsSync <= 1'b0;
      failExpAddr <= '0;
      failExpData <= '0;
      failExpSync <= 1'b0;
    end else if (strb.latchMiss && !failFlag) begin
      failFlag    <= 1'b1;
      failIdx     <= effIdx;
      failObsAddr <= busAddr;
      failObsData <= busData;
      failObsSync <= busSync;
      failExpAddr <= expE.addr;
      failExpData <= expE.data;
      failExpSync <= expE.sync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearErr)
      syncErr <= 1'b0;
    else if (strb.flagSync)
      syncErr <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      loopCount <= '0;
    else if (strb.bumpCount && (loopCount != '1))
      loopCount <= loopCount + 1'b1;
  end

  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !clearErr) |=> (failFlag && $stable(failIdx)
      && $stable(failObsAddr) && $stable(failExpAddr) && $stable(failObsData)));
  // R5
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncErr && !clearErr) |=> syncErr);
  // R7
  count_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (loopCount >= $past(loopCount)));
  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loopCount == '1) |=> (loopCount == '1));
  // R9
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loopLen >= LEN_W'(1)) && (loopLen <= LEN_W'(DEPTH)));
endmodule

// File: rtl/bus_loop_checker.sv
module bus_loop_checker
  import blc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEn,
  input  logic [15:0]      busAddr,
  input  logic [7:0]       busData,
  input  logic             busSync,
  input  logic             cfgWr,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [15:0]      cfgAddr,
  input  logic [15:0]      cfgAddrCare,
  input  logic [7:0]       cfgData,
  input  logic [7:0]       cfgDataCare,
  input  logic             cfgSync,
  input  logic             cfgLenWr,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             clearErr,
  output logic             aligned,
  output logic             passFlag,
  output logic             failFlag,
  output logic             syncErr,
  output logic [IDX_W-1:0] failIdx,
  output logic [15:0]      failObsAddr,
  output logic [7:0]       failObsData,
  output logic             failObsSync,
  output logic [15:0]      failExpAddr,
  output logic [7:0]       failExpData,
  output logic             failExpSync,
  output logic [15:0]      loopCount
);
  ctlStrobe_t       strb;
  cycEntry_t        cfgEntry;
  logic [IDX_W-1:0] idx, effIdx, lastIdx;
  logic             curEntrySync, mismatch;

  assign cfgEntry = '{addr: cfgAddr, addrCare: cfgAddrCare, data: cfgData,
                      dataCare: cfgDataCare, sync: cfgSync};
  assign passFlag = (loopCount != '0) && !failFlag && !syncErr;

  blc_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .busSync(busSync),
    .lenWr(cfgLenWr), .curEntrySync(curEntrySync), .lastIdx(lastIdx),
    .mismatch(mismatch), .idx(idx), .effIdx(effIdx), .aligned(aligned),
    .strb(strb)
  );

  blc_dpath #(.DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgIdx(cfgIdx), .cfgEntry(cfgEntry),
    .cfgLenWr(cfgLenWr), .cfgLen(cfgLen), .clearErr(clearErr),
    .busAddr(busAddr), .busData(busData), .busSync(busSync),
    .idx(idx), .effIdx(effIdx), .strb(strb),
    .curEntrySync(curEntrySync), .lastIdx(lastIdx), .mismatch(mismatch),
    .failFlag(failFlag), .syncErr(syncErr), .failIdx(failIdx),
    .failObsAddr(failObsAddr), .failObsData(failObsData), .failObsSync(failObsSync),
    .failExpAddr(failExpAddr), .failExpData(failExpData), .failExpSync(failExpSync),
    .loopCount(loopCount)
  );
endmodule

// File: tb/bus_loop_checker_tb_top.sv
module bus_loop_checker_tb_top;
  localparam int DEPTH = 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0, busSync = 1'b0, cfgWr = 1'b0, cfgSync = 1'b0;
  logic cfgLenWr = 1'b0, clearErr = 1'b0;
  logic [15:0] busAddr = '0, cfgAddr = '0, cfgAddrCare = '0;
  logic [7:0]  busData = '0, cfgData = '0, cfgDataCare = '0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [LEN_W-1:0] cfgLen = '0;
  logic aligned, passFlag, failFlag, syncErr, failObsSync, failExpSync;
  logic [IDX_W-1:0] failIdx;
  logic [15:0] failObsAddr, failExpAddr, loopCount;
  logic [7:0]  failObsData, failExpData;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_loop_checker #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic busCyc(input logic [15:0] a, input logic [7:0] d, input logic s, input logic en);
    @(negedge clk);
    busAddr = a; busData = d; busSync = s; sampleEn = en;
    @(posedge clk); #1;
    sampleEn = 1'b0;
  endtask

  task automatic jmpPass();
    busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    busCyc(16'hC001, 8'h00, 1'b0, 1'b1);
    busCyc(16'hC002, 8'hC0, 1'b0, 1'b1);
  endtask

  task automatic wrEntry(input int i, input logic [15:0] a, input logic [15:0] ac,
                         input logic [7:0] d, input logic [7:0] dc, input logic s);
    @(negedge clk);
    cfgWr = 1'b1; cfgIdx = IDX_W'(i); cfgAddr = a; cfgAddrCare = ac;
    cfgData = d; cfgDataCare = dc; cfgSync = s;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic wrLen(input int n);
    @(negedge clk); cfgLenWr = 1'b1; cfgLen = LEN_W'(n);
    @(negedge clk); cfgLenWr = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); clearErr = 1'b1;
    @(negedge clk); clearErr = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state
    chkEq("R1 aligned", aligned, 0);
    chkEq("R1 failFlag", failFlag, 0);
    chkEq("R1 syncErr", syncErr, 0);
    chkEq("R1 loopCount", loopCount, 0);
    chkEq("R1 passFlag", passFlag, 0);

    // R10: three-cycle jump loop
    wrEntry(0, 16'hC000, 16'hFFFF, 8'h4C, 8'hFF, 1'b1);
    wrEntry(1, 16'hC001, 16'hFFFF, 8'h00, 8'hFF, 1'b0);
    wrEntry(2, 16'hC002, 16'hFFFF, 8'hC0, 8'hFF, 1'b0);
    wrLen(3);

    // R1: rotated entry, no SYNC yet
    busCyc(16'hC001, 8'h00, 1'b0, 1'b1);
    busCyc(16'hC002, 8'hC0, 1'b0, 1'b1);
    chkEq("R1 unaligned before sync", aligned, 0);
    chkEq("R1 no failure before sync", failFlag, 0);

    // R2, R10, R8: four clean passes
    for (int p = 0; p < 4; p++) jmpPass();
    chkEq("R2 aligned", aligned, 1);
    chkEq("R2 count after 4 passes", loopCount, 4);
    chkEq("R10 table drives compare", failFlag, 0);
    chkEq("R8 passFlag", passFlag, 1);

    // R4: garbage between strobes
    busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    busCyc(16'h1234, 8'h55, 1'b1, 1'b0);
    busCyc(16'hC001, 8'h00, 1'b0, 1'b1);
    busCyc(16'hFFFF, 8'hAA, 1'b0, 1'b0);
    busCyc(16'hC002, 8'hC0, 1'b0, 1'b1);
    chkEq("R4 gaps ignored count", loopCount, 5);
    chkEq("R4 gaps ignored fail", failFlag, 0);
    chkEq("R4 gaps ignored sync", syncErr, 0);

    // R3, R6: wrong address on second cycle
    busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    busCyc(16'hC005, 8'h00, 1'b0, 1'b1);
    busCyc(16'hC002, 8'hC0, 1'b0, 1'b1);
    chkEq("R3 addr mismatch flag", failFlag, 1);
    chkEq("R6 failIdx", failIdx, 1);
    chkEq("R6 obs addr", failObsAddr, 16'hC005);
    chkEq("R6 exp addr", failExpAddr, 16'hC001);
    chkEq("R7 bad pass not counted", loopCount, 5);
    chkEq("R8 passFlag low on fail", passFlag, 0);
    jmpPass();
    chkEq("R7 clean pass after fail", loopCount, 6);
    // R6: second failure does not overwrite
    busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    busCyc(16'hC001, 8'h11, 1'b0, 1'b1);
    busCyc(16'hC002, 8'hC0, 1'b0, 1'b1);
    chkEq("R6 held idx", failIdx, 1);
    chkEq("R6 held obs data", failObsData, 8'h00);
    chkEq("R6 held obs addr", failObsAddr, 16'hC005);
    chkEq("R7 data-bad pass not counted", loopCount, 6);
    pulseClear();
    chkEq("R6 clear flag", failFlag, 0);
    chkEq("R6 clear idx", failIdx, 0);
    chkEq("R6 clear addr", failObsAddr, 0);

    // R3: masked data bits
    wrEntry(1, 16'hC001, 16'hFFFF, 8'h00, 8'h00, 1'b0);
    busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    busCyc(16'hC001, 8'hFF, 1'b0, 1'b1);
    busCyc(16'hC002, 8'hC0, 1'b0, 1'b1);
    chkEq("R3 masked data no fail", failFlag, 0);
    chkEq("R3 masked pass counted", loopCount, 7);

    // R3: missing SYNC on opcode fetch
    busCyc(16'hC000, 8'h4C, 1'b0, 1'b1);
    busCyc(16'hC001, 8'h00, 1'b0, 1'b1);
    busCyc(16'hC002, 8'hC0, 1'b0, 1'b1);
    chkEq("R3 sync mismatch flag", failFlag, 1);
    chkEq("R3 sync mismatch idx", failIdx, 0);
    chkEq("R3 obs sync", failObsSync, 0);
    chkEq("R3 exp sync", failExpSync, 1);
    chkEq("R3 sync-bad pass not counted", loopCount, 7);
    pulseClear();

    // R5: misplaced SYNC realigns
    busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    chkEq("R5 syncErr set", syncErr, 1);
    busCyc(16'hC001, 8'h00, 1'b0, 1'b1);
    busCyc(16'hC002, 8'hC0, 1'b0, 1'b1);
    chkEq("R5 realigned no fail", failFlag, 0);
    chkEq("R5 realigned pass counted", loopCount, 8);
    chkEq("R8 passFlag low on syncErr", passFlag, 0);
    pulseClear();
    chkEq("R5 syncErr cleared", syncErr, 0);
    chkEq("R8 passFlag after clear", passFlag, 1);

    // R5: seven-cycle load plus jump loop, SYNC kept at entry 4
    doReset();
    wrEntry(0, 16'hC000, 16'hFFFF, 8'hAD, 8'hFF, 1'b1);
    wrEntry(1, 16'hC001, 16'hFFFF, 8'h00, 8'hFF, 1'b0);
    wrEntry(2, 16'hC002, 16'hFFFF, 8'h80, 8'hFF, 1'b0);
    wrEntry(3, 16'h8000, 16'hFFFF, 8'h00, 8'h00, 1'b0);
    wrEntry(4, 16'hC003, 16'hFFFF, 8'h4C, 8'hFF, 1'b1);
    wrEntry(5, 16'hC004, 16'hFFFF, 8'h00, 8'hFF, 1'b0);
    wrEntry(6, 16'hC005, 16'hFFFF, 8'hC0, 8'hFF, 1'b0);
    wrLen(7);
    for (int p = 0; p < 3; p++) begin
      busCyc(16'hC000, 8'hAD, 1'b1, 1'b1);
      busCyc(16'hC001, 8'h00, 1'b0, 1'b1);
      busCyc(16'hC002, 8'h80, 1'b0, 1'b1);
      busCyc(16'h8000, 8'(p * 37 + 5), 1'b0, 1'b1);
      busCyc(16'hC003, 8'h4C, 1'b1, 1'b1);
      busCyc(16'hC004, 8'h00, 1'b0, 1'b1);
      busCyc(16'hC005, 8'hC0, 1'b0, 1'b1);
    end
    chkEq("R5 two syncs per pass kept", syncErr, 0);
    chkEq("R2 seven-cycle count", loopCount, 3);
    chkEq("R2 seven-cycle no fail", failFlag, 0);

    // R9: length clamp low and high
    doReset();
    wrEntry(0, 16'hC000, 16'hFFFF, 8'h4C, 8'hFF, 1'b1);
    wrLen(0);
    for (int p = 0; p < 3; p++) busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    chkEq("R9 zero length acts as one", loopCount, 3);
    wrLen(12);
    chkEq("R9 length write drops alignment", aligned, 0);
    busCyc(16'hC000, 8'h4C, 1'b1, 1'b1);
    for (int k = 1; k < 8; k++) busCyc(16'(16'h0100 + k), 8'h00, 1'b0, 1'b1);
    chkEq("R9 oversize length clamps to depth", loopCount, 4);
    chkEq("R9 clamped pass clean", failFlag, 0);

    // R7: saturation with a one-entry loop
    doReset();
    wrEntry(0, 16'hC000, 16'hFFFF, 8'h4C, 8'hFF, 1'b1);
    wrLen(1);
    @(negedge clk);
    busAddr = 16'hC000; busData = 8'h4C; busSync = 1'b1; sampleEn = 1'b1;
    repeat (65540) @(posedge clk);
    #1 sampleEn = 1'b0;
    @(negedge clk);
    chkEq("R7 saturated count", loopCount, 16'hFFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule